// File: doc/BRIEF.md
# Power-Down Wake-Up Reset Sequencer

This block decides how a small processor core comes back from power-down when its external reset pin is raised. While the core runs, a one-cycle power-down request from the core stops the oscillator and gates the core clock. A later rising edge on the reset pin wakes the block. That edge turns the oscillator enable back on through an asynchronous path, without waiting for a clock edge. A start-up counter then runs for a time-out chosen by a two-bit select. The core clock stays gated until that count completes.

When the core clock comes back, the internal reset depends on the pin level at time-out. If the pin has already dropped, the core gets a fixed reset pulse of two cycles. If the pin is still high, the reset lasts until the pin is released. A pin that rises while the core runs simply holds the core in reset for as long as the pin stays high, with no start-up delay.

The reset pin is active high and passes through a two-stage synchronizer before the state machine sees it. The oscillator is modelled as a plain enable, and the block clock keeps running throughout.

Top module: `pd_wake_seq`

## Requirements
- R1: When `rst_n` is released, the block is in the running state, with `osc_en`=1, `clk_en`=1 and `cpu_rst`=0.
- R2: A one-cycle high on `pd_req` in the running state, with the pin low, gives `osc_en`=0 and `clk_en`=0 from the following cycle on, and the block stays asleep while the pin stays low.
- R3: While the block sleeps, a high level on `rst_pin` drives `osc_en` high at once, without waiting for a clock edge.
- R4: After a pin rising edge in sleep, `clk_en` stays 0 and first reads 1 exactly L+3 cycles after the edge. The 3 cycles are two synchronizer stages and one detection stage. L is set by `sut_sel`: 0 gives 16, 1 gives 256, 2 gives 1024 and 3 gives 4096 cycles.
- R5: If the pin is low when the start-up count ends, `cpu_rst` is 1 for exactly the first two cycles in which `clk_en` is back to 1, then returns to 0.
- R6: If the pin is still high when the start-up count ends, `cpu_rst` stays 1 while the pin stays high and falls 3 cycles after the pin falls.
- R7: A pin rising edge while running raises `cpu_rst` 3 cycles after the edge with `clk_en` kept at 1. `cpu_rst` then stays 1 until 3 cycles after the pin falls.
- R8: `pd_req` has no effect during start-up: the clock comes back at the same cycle as in R4.
- R9: The state register is one-hot, and any other encoding leads back to the running state with `cpu_rst` asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator-domain clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| pd_req | input | 1 | One-cycle power-down request from the core |
| rst_pin | input | 1 | External reset pin, active high, asynchronous |
| sut_sel | input | 2 | Start-up time-out select, fixed before operation |
| osc_en | output | 1 | Oscillator enable |
| clk_en | output | 1 | Enable for the gated core clock |
| cpu_rst | output | 1 | Internal reset to the core, active high |

## Verification
The bench counts the exact cycle at which the clock returns for several time-out selects. A synchronizer or counter off by one, or a select that picks the wrong length, moves that cycle and is caught. It checks the reset pulse cycle by cycle, so a pulse of one or three cycles fails, and so does a pulse issued while the pin is still high. A pin still held at time-out must keep the core in reset until release. A design that always pulses would drop the reset early. The bench also checks that the oscillator wakes asynchronously, that a pin in the running state gives a plain reset with no clock gating, and that a stray power-down request during start-up changes nothing.

// File: rtl/pd_wake_pkg.sv
`timescale 1ns/1ps
package pd_wake_pkg;

    // One-hot sequencer states
    typedef enum logic [4:0] {
        ST_RUN     = 5'b00001,
        ST_SLEEP   = 5'b00010,
        ST_STARTUP = 5'b00100,
        ST_PULSE   = 5'b01000,
        ST_HOLD    = 5'b10000
    } pd_st_e;

endpackage

// File: rtl/pd_wake_sync.sv
`timescale 1ns/1ps
module pd_wake_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl,
    output logic rise
);
    // STAGES synchronizer flops plus one delay flop for edge detection
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign lvl  = sh_q[STAGES-1];
    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/pd_wake_timer.sv
`timescale 1ns/1ps
module pd_wake_timer #(
    parameter int unsigned CNT_W  = 12,
    parameter int unsigned LOG2_0 = 4,
    parameter int unsigned LOG2_1 = 8,
    parameter int unsigned LOG2_2 = 10,
    parameter int unsigned LOG2_3 = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic [1:0] sel,
    output logic       done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] term;

    // Terminal count is one less than the selected length
    always_comb begin
        case (sel)
            2'd0:    term = CNT_W'((1 << LOG2_0) - 1);
            2'd1:    term = CNT_W'((1 << LOG2_1) - 1);
            2'd2:    term = CNT_W'((1 << LOG2_2) - 1);
            default: term = CNT_W'((1 << LOG2_3) - 1);
        endcase
    end

    always_comb begin
        cnt_d = cnt_q;
        if (clr)     cnt_d = '0;
        else if (en) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = en && (cnt_q == term);
endmodule

// File: rtl/pd_wake_fsm.sv
`timescale 1ns/1ps
module pd_wake_fsm
    import pd_wake_pkg::*;
#(
    parameter int unsigned PULSE_LEN = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pd_req,
    input  logic       lvl,
    input  logic       rise,
    input  logic       done,
    output logic [4:0] st,
    output logic       tmr_clr,
    output logic       tmr_en,
    output logic       osc_req,
    output logic       clk_en,
    output logic       cpu_rst
);
    localparam int unsigned PCNT_W = (PULSE_LEN > 2) ? $clog2(PULSE_LEN) : 1;

    typedef struct packed {
        pd_st_e            st;
        logic [PCNT_W-1:0] pcnt;
    } fsm_t;

    fsm_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_RUN: begin
                if (lvl)         r_d.st = ST_HOLD;
                else if (pd_req) r_d.st = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (rise) r_d.st = ST_STARTUP;
            end
            ST_STARTUP: begin
                r_d.pcnt = '0;
                if (done) r_d.st = lvl ? ST_HOLD : ST_PULSE;
            end
            ST_PULSE: begin
                if (r_q.pcnt == PCNT_W'(PULSE_LEN - 1)) r_d.st = ST_RUN;
                else                                   r_d.pcnt = r_q.pcnt + 1'b1;
            end
            ST_HOLD: begin
                if (!lvl) r_d.st = ST_RUN;
            end
            default: begin
                r_d.st   = ST_RUN;
                r_d.pcnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_RUN;
            r_q.pcnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // Output decode; an illegal encoding keeps the clock and asserts reset
    always_comb begin
        tmr_clr = 1'b0;
        tmr_en  = 1'b0;
        osc_req = 1'b1;
        clk_en  = 1'b1;
        cpu_rst = 1'b0;
        case (r_q.st)
            ST_RUN: ;
            ST_SLEEP: begin
                tmr_clr = 1'b1;
                osc_req = 1'b0;
                clk_en  = 1'b0;
            end
            ST_STARTUP: begin
                tmr_en = 1'b1;
                clk_en = 1'b0;
            end
            ST_PULSE: cpu_rst = 1'b1;
            ST_HOLD:  cpu_rst = 1'b1;
            default:  cpu_rst = 1'b1;
        endcase
    end

    assign st = r_q.st;
endmodule

// File: rtl/pd_wake_seq.sv
`timescale 1ns/1ps
module pd_wake_seq #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned PULSE_LEN   = 2,
    parameter int unsigned CNT_W       = 12,
    parameter int unsigned LOG2_0      = 4,
    parameter int unsigned LOG2_1      = 8,
    parameter int unsigned LOG2_2      = 10,
    parameter int unsigned LOG2_3      = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pd_req,
    input  logic       rst_pin,
    input  logic [1:0] sut_sel,
    output logic       osc_en,
    output logic       clk_en,
    output logic       cpu_rst
);
    logic       pin_lvl, pin_rise, tmr_done, tmr_clr, tmr_en, osc_req;
    logic [4:0] st_w;

    pd_wake_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (rst_pin),
        .lvl  (pin_lvl),
        .rise (pin_rise)
    );

    pd_wake_timer #(
        .CNT_W (CNT_W),
        .LOG2_0(LOG2_0),
        .LOG2_1(LOG2_1),
        .LOG2_2(LOG2_2),
        .LOG2_3(LOG2_3)
    ) timer_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tmr_clr),
        .en   (tmr_en),
        .sel  (sut_sel),
        .done (tmr_done)
    );

    pd_wake_fsm #(.PULSE_LEN(PULSE_LEN)) fsm_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pd_req (pd_req),
        .lvl    (pin_lvl),
        .rise   (pin_rise),
        .done   (tmr_done),
        .st     (st_w),
        .tmr_clr(tmr_clr),
        .tmr_en (tmr_en),
        .osc_req(osc_req),
        .clk_en (clk_en),
        .cpu_rst(cpu_rst)
    );

    // Asynchronous wake path: the raw pin restarts the oscillator directly
    assign osc_en = osc_req | rst_pin;
endmodule

// File: rtl/pd_wake_chk.sv
`timescale 1ns/1ps
module pd_wake_chk
    import pd_wake_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       pd_req,
    input logic       rst_pin,
    input logic       osc_en,
    input logic       clk_en,
    input logic       cpu_rst,
    input logic [4:0] st,
    input logic       lvl
);
    // R9: state register always one-hot
    p_state_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(st));

    // R2: request while running with pin low gates the clock next cycle
    p_sleep_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && pd_req && !lvl) |=> !clk_en);

    // R3: raw pin level always keeps the oscillator on
    p_async_osc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pin |-> osc_en);

    // R4: no core clock while the oscillator is off
    p_clk_needs_osc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !clk_en);

    // R5: clock returns only together with an internal reset
    p_wake_with_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_en) |-> cpu_rst);

    // R5: the pulse lasts at least a second cycle
    p_pulse_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PULSE && $rose(cpu_rst)) |=> cpu_rst);

    // R6: reset held while pin still high
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD && lvl) |=> cpu_rst);

    // R7: pin high while running leads to reset with the clock kept on
    p_run_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && lvl) |=> (cpu_rst && clk_en));
endmodule

bind pd_wake_seq pd_wake_chk chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .pd_req (pd_req),
    .rst_pin(rst_pin),
    .osc_en (osc_en),
    .clk_en (clk_en),
    .cpu_rst(cpu_rst),
    .st     (st_w),
    .lvl    (pin_lvl)
);

// File: tb/pd_wake_seq_tb_top.sv
`timescale 1ns/1ps
module pd_wake_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pd_req = 1'b0;
    logic       rst_pin = 1'b0;
    logic [1:0] sut_sel = 2'd0;
    logic       osc_en, clk_en, cpu_rst;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    pd_wake_seq dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pd_req (pd_req),
        .rst_pin(rst_pin),
        .sut_sel(sut_sel),
        .osc_en (osc_en),
        .clk_en (clk_en),
        .cpu_rst(cpu_rst)
    );

    task automatic chk_bit(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int sut_len(input logic [1:0] s);
        case (s)
            2'd0:    return 16;
            2'd1:    return 256;
            2'd2:    return 1024;
            default: return 4096;
        endcase
    endfunction

    // R1: state after power-on reset
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_bit("R1", "osc_en", osc_en, 1'b1);
        chk_bit("R1", "clk_en", clk_en, 1'b1);
        chk_bit("R1", "cpu_rst", cpu_rst, 1'b0);
    endtask

    // R2: enter sleep from run
    task automatic go_sleep();
        @(negedge clk) pd_req = 1'b1;
        @(negedge clk) pd_req = 1'b0;
        chk_bit("R2", "osc_en after request", osc_en, 1'b0);
        chk_bit("R2", "clk_en after request", clk_en, 1'b0);
        repeat (3) @(negedge clk);
        chk_bit("R2", "clk_en stays off", clk_en, 1'b0);
    endtask

    // R3 R4 R5 R8: wake with the pin released before the time-out
    task automatic t_wake_release(input logic [1:0] s, input bit pd_in_startup);
        int n = 0;
        sut_sel = s;
        go_sleep();
        @(negedge clk) rst_pin = 1'b1;
        #1;
        chk_bit("R3", "osc_en async", osc_en, 1'b1);
        chk_bit("R4", "clk_en at wake edge", clk_en, 1'b0);
        while (clk_en !== 1'b1 && n < 6000) begin
            @(negedge clk);
            n++;
            if (n == 5) rst_pin = 1'b0;
            if (pd_in_startup && n == 8) pd_req = 1'b1;
            if (n == 9) pd_req = 1'b0;
        end
        chk_int(pd_in_startup ? "R8" : "R4", "cycles to clock return", n, sut_len(s) + 3);
        chk_bit("R5", "reset pulse cycle 1", cpu_rst, 1'b1);
        @(negedge clk);
        chk_bit("R5", "reset pulse cycle 2", cpu_rst, 1'b1);
        chk_bit("R5", "clk_en in pulse", clk_en, 1'b1);
        @(negedge clk);
        chk_bit("R5", "reset pulse ended", cpu_rst, 1'b0);
        chk_bit("R5", "clk_en after pulse", clk_en, 1'b1);
    endtask

    // R4 R6: wake with the pin held past the time-out
    task automatic t_wake_hold(input logic [1:0] s);
        int n = 0;
        sut_sel = s;
        go_sleep();
        @(negedge clk) rst_pin = 1'b1;
        while (clk_en !== 1'b1 && n < 6000) begin
            @(negedge clk);
            n++;
        end
        chk_int("R4", "cycles to clock return (held)", n, sut_len(s) + 3);
        for (int i = 0; i < 6; i++) begin
            chk_bit("R6", "reset held with pin high", cpu_rst, 1'b1);
            @(negedge clk);
        end
        rst_pin = 1'b0;
        @(negedge clk);
        chk_bit("R6", "reset 1 cycle after release", cpu_rst, 1'b1);
        @(negedge clk);
        chk_bit("R6", "reset 2 cycles after release", cpu_rst, 1'b1);
        @(negedge clk);
        chk_bit("R6", "reset 3 cycles after release", cpu_rst, 1'b0);
    endtask

    // R7: pin while running
    task automatic t_run_reset();
        @(negedge clk) rst_pin = 1'b1;
        @(negedge clk);
        chk_bit("R7", "no reset after 1 cycle", cpu_rst, 1'b0);
        @(negedge clk);
        chk_bit("R7", "no reset after 2 cycles", cpu_rst, 1'b0);
        @(negedge clk);
        chk_bit("R7", "reset after 3 cycles", cpu_rst, 1'b1);
        chk_bit("R7", "clock kept running", clk_en, 1'b1);
        repeat (4) @(negedge clk);
        chk_bit("R7", "reset still held", cpu_rst, 1'b1);
        rst_pin = 1'b0;
        repeat (2) @(negedge clk);
        chk_bit("R7", "reset 2 cycles after release", cpu_rst, 1'b1);
        @(negedge clk);
        chk_bit("R7", "reset released", cpu_rst, 1'b0);
    endtask

    initial begin
        t_reset();
        t_wake_release(2'd0, 1'b0);
        t_wake_release(2'd1, 1'b0);
        t_wake_hold(2'd0);
        t_run_reset();
        t_wake_release(2'd0, 1'b1);
        t_wake_release(2'd2, 1'b0);
        t_wake_hold(2'd3);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog all requirements: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule